// File: doc/BRIEF.md
# Per-Port Input Change Interrupt

This block raises the interrupt of a two-port general-purpose I/O expander. Every pin level is brought into the clock domain through a short synchroniser chain. Each port then compares its synchronised levels against a snapshot of that port. The snapshot is refreshed only when software reads that port's input register. Any pin that is configured as an input and no longer matches its snapshot flags its port. The flags of both ports are merged into one registered, active-low request that is meant to drive an open-drain pad.

The request is level-based. It goes away by itself when the changed pin goes back to the level held in the snapshot. It also goes away when the owning port is read, because the read takes a fresh snapshot. A read of one port leaves the other port's pending change in place. Turning an output pin into an input is allowed to raise the request if the pin level differs from the snapshot. Reset loads the snapshots with the live levels, so the block leaves reset quiet.

Top module: `port_change_irq`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `irq_n` is 1, provided the pins are stable during reset.
- R2: When a pin whose `dir_in` bit is 1 (1 = input) changes to a level that differs from its port snapshot, `irq_n` goes to 0 on the third rising clock edge after the change. The path is two synchroniser stages and then the output register.
- R3: A pin whose `dir_in` bit is 0 (output) never pulls `irq_n` low, whatever its level does.
- R4: When every mismatching input pin goes back to its snapshot level, `irq_n` returns to 1 on the third rising edge after that return.
- R5: A one-cycle pulse on `rd_cap[p]` copies the synchronised levels of port p into its snapshot at that edge. A change pending on port p then stops requesting, and `irq_n` is 1 one edge later when no other port is flagging. Port p covers `pin_lvl[8p+7:8p]`.
- R6: A pulse on `rd_cap` for one port does not clear a mismatch pending on the other port.
- R7: Changing a `dir_in` bit from 0 to 1 while that pin differs from its snapshot pulls `irq_n` low on the next rising edge.
- R8: `irq_n` is registered. On every cycle after reset it equals the inverted OR of the per-port mismatch flags from the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; snapshots follow the live levels while it is low |
| pin_lvl | input | 16 | Raw pin levels; bits 8p+7..8p belong to port p |
| dir_in | input | 16 | Direction per pin, 1 = input, 0 = output |
| rd_cap | input | 2 | One pulse per read of port p's input register; refreshes that snapshot |
| irq_n | output | 1 | Active-low interrupt request for an open-drain pad |

## Verification
A pin change reaches `irq_n` three edges later: two synchroniser flops and then the output register. A change of a direction bit or a read pulse reaches it one edge later, through the output register alone. The bench drives every stimulus on the falling edge and counts rising edges from there. It samples `irq_n` on the falling edge one cycle before the due edge, where the old value must still show, and again on the due edge. This pins down both the value and its latency. Each isolation case is checked after its stimulus and before the next one, which shows that a read of the other port or an output-pin toggle leaves the request where it was.

// File: rtl/port_change_irq_pkg.sv
package port_change_irq_pkg;
  localparam int unsigned DEF_PORT_W   = 8;
  localparam int unsigned DEF_PORTS    = 2;
  localparam int unsigned DEF_SYNC_LEN = 2;
endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_raw,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] chain [STAGES];

  // The chain has no reset, so it keeps sampling while reset is held.
  // The snapshots can then be preloaded from it.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) chain[s] <= d_raw;
      end else begin : g_next
        always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/pcirq_port.sv
module pcirq_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dir_in,
  input  logic         rd_cap,
  output logic         flag
);
  logic [W-1:0] snap;

  // A pin counts only when it is an input and its level has moved away from the snapshot.
  function automatic logic port_mismatch(input logic [W-1:0] live,
                                         input logic [W-1:0] held,
                                         input logic [W-1:0] is_in);
    return |((live ^ held) & is_in);
  endfunction

  // Reset and each read both take a copy of the live levels.
  always_ff @(posedge clk) begin
    if (!rst_n || rd_cap) snap <= lvl;
  end

  assign flag = port_mismatch(lvl, snap, dir_in);
endmodule

// File: rtl/pcirq_merge.sv
module pcirq_merge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  output logic         req_n
);
  function automatic logic merge_n(input logic [N-1:0] f);
    return ~(|f);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_n <= 1'b1;
    else        req_n <= merge_n(flags);
  end
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
  import port_change_irq_pkg::*;
#(
  parameter int unsigned PORT_W    = DEF_PORT_W,
  parameter int unsigned NUM_PORTS = DEF_PORTS,
  parameter int unsigned SYNC_LEN  = DEF_SYNC_LEN
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_lvl,
  input  logic [NUM_PORTS*PORT_W-1:0] dir_in,
  input  logic [NUM_PORTS-1:0]        rd_cap,
  output logic                        irq_n
);
  localparam int unsigned PIN_W = NUM_PORTS * PORT_W;

  // Named internal wires, kept visible for the bound checker.
  logic [PIN_W-1:0]     sync_lvl;
  logic [NUM_PORTS-1:0] port_flag;

  pcirq_sync #(.W(PIN_W), .STAGES(SYNC_LEN)) u_sync (
    .clk    (clk),
    .d_raw  (pin_lvl),
    .d_sync (sync_lvl)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      pcirq_port #(.W(PORT_W)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (sync_lvl[p*PORT_W +: PORT_W]),
        .dir_in (dir_in[p*PORT_W +: PORT_W]),
        .rd_cap (rd_cap[p]),
        .flag   (port_flag[p])
      );
    end
  endgenerate

  pcirq_merge #(.N(NUM_PORTS)) u_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (port_flag),
    .req_n (irq_n)
  );
endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk #(
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned NUM_PORTS = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_PORTS*PORT_W-1:0] dir_in,
  input logic [NUM_PORTS-1:0]        rd_cap,
  input logic [NUM_PORTS*PORT_W-1:0] sync_lvl,
  input logic [NUM_PORTS-1:0]        port_flag,
  input logic                        irq_n
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_n);

  // R8
  irq_registered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_n == !$past(|port_flag)));

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pchk
      // R3
      output_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in[p*PORT_W +: PORT_W] == '0) |-> !port_flag[p]);

      // R5
      read_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_cap[p]) && $stable(sync_lvl[p*PORT_W +: PORT_W]))
          |-> !port_flag[p]);

      // R6
      flag_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(port_flag[p]) && !$past(rd_cap[p])
          && $stable(sync_lvl[p*PORT_W +: PORT_W])
          && $stable(dir_in[p*PORT_W +: PORT_W])) |-> port_flag[p]);
    end
  endgenerate
endmodule

bind port_change_irq port_change_irq_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_in    (dir_in),
  .rd_cap    (rd_cap),
  .sync_lvl  (sync_lvl),
  .port_flag (port_flag),
  .irq_n     (irq_n)
);

// File: tb/port_change_irq_tb.sv
`timescale 1ns/1ps
module port_change_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_lvl = 16'hA5C3;
  logic [15:0] dir_in  = 16'hFFFF;
  logic [1:0]  rd_cap  = 2'b00;
  logic        irq_n;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  port_change_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .dir_in(dir_in),
    .rd_cap(rd_cap), .irq_n(irq_n)
  );

  // Wait n rising edges; return just after the following falling edge.
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s irq_n actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd_port(input int p);
    rd_cap[p] = 1'b1;
    edges(1);
    rd_cap[p] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", irq_n, 1'b1);
    edges(8);
    rst_n = 1'b1;
    chk("R1", irq_n, 1'b1);
    edges(4);
    chk("R1", irq_n, 1'b1);
  endtask

  task automatic t_change_return;
    pin_lvl[3] = ~pin_lvl[3];
    edges(2);
    chk("R2", irq_n, 1'b1);
    edges(1);
    chk("R2", irq_n, 1'b0);
    pin_lvl[3] = ~pin_lvl[3];
    edges(2);
    chk("R4", irq_n, 1'b0);
    edges(1);
    chk("R4", irq_n, 1'b1);
  endtask

  task automatic t_output_pin;
    dir_in[12] = 1'b0;
    edges(1);
    pin_lvl[12] = ~pin_lvl[12];
    edges(5);
    chk("R3", irq_n, 1'b1);
    pin_lvl[12] = ~pin_lvl[12];
    edges(4);
    dir_in[12] = 1'b1;
    edges(2);
    chk("R3", irq_n, 1'b1);
  endtask

  task automatic t_read_clear;
    pin_lvl[8] = ~pin_lvl[8];
    edges(3);
    chk("R2", irq_n, 1'b0);
    rd_cap[1] = 1'b1;
    edges(1);
    rd_cap[1] = 1'b0;
    chk("R5", irq_n, 1'b0);
    edges(1);
    chk("R5", irq_n, 1'b1);
    // The snapshot now holds the new level, so restoring the pin is itself a change.
    pin_lvl[8] = ~pin_lvl[8];
    edges(3);
    chk("R5", irq_n, 1'b0);
    rd_port(1);
    edges(1);
    chk("R5", irq_n, 1'b1);
  endtask

  task automatic t_isolation;
    pin_lvl[7]  = ~pin_lvl[7];
    pin_lvl[14] = ~pin_lvl[14];
    edges(4);
    chk("R2", irq_n, 1'b0);
    rd_port(1);
    edges(3);
    chk("R6", irq_n, 1'b0);
    rd_port(0);
    edges(1);
    chk("R5", irq_n, 1'b1);
    pin_lvl[0] = ~pin_lvl[0];
    edges(4);
    rd_port(1);
    edges(3);
    chk("R6", irq_n, 1'b0);
    rd_port(0);
    edges(1);
    chk("R6", irq_n, 1'b1);
  endtask

  task automatic t_dir_switch;
    dir_in[2] = 1'b0;
    edges(1);
    pin_lvl[2] = ~pin_lvl[2];
    edges(5);
    chk("R3", irq_n, 1'b1);
    dir_in[2] = 1'b1;
    chk("R7", irq_n, 1'b1);
    edges(1);
    chk("R7", irq_n, 1'b0);
    rd_port(0);
    edges(1);
    chk("R7", irq_n, 1'b1);
  endtask

  task automatic t_multi;
    pin_lvl[5]  = ~pin_lvl[5];
    pin_lvl[10] = ~pin_lvl[10];
    edges(3);
    chk("R2", irq_n, 1'b0);
    pin_lvl[5] = ~pin_lvl[5];
    edges(4);
    chk("R4", irq_n, 1'b0);
    pin_lvl[10] = ~pin_lvl[10];
    edges(3);
    chk("R4", irq_n, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_change_return();
    t_output_pin();
    t_read_clear();
    t_isolation();
    t_dir_switch();
    t_multi();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule